// File: doc/BRIEF.md
# Queued Command Tag Tracker

This block keeps the record of which queued disk commands are still outstanding. It holds one pending bit per command tag. Software marks a tag as pending through a set-mask write before it issues the command that carries that tag. The device later reports finished commands in a completion frame, which carries a 32-bit mask of completed tags. The block clears those tags in hardware. Software never clears a pending bit, and the device never sets one, so set traffic and clear traffic can arrive in the same cycle without a race.

The pending vector is always visible on `active_tags`. A second vector, `done_tags`, records every tag that a completion frame actually retired, meaning the tag was pending when the frame arrived. Software clears a `done_tags` bit by writing 1 to it. Completions are counted and merged into a single interrupt. The interrupt rises when the count of unacknowledged completions reaches a programmable threshold, or when a programmable number of cycles has passed since the first unacknowledged completion. It stays high until software acknowledges it. Readiness to accept new commands is handled elsewhere and is independent of this record.

Top module: `cmdq_tag_tracker`

## Requirements
- R1: After a synchronous reset, `active_tags` and `done_tags` are all zeros and `irq` is low.
- R2: When `set_valid` is high, the register becomes `active_tags | set_mask` on the next clock edge. Bit n of the mask is tag n. Zero bits in the mask, and any cycle with `set_valid` low, leave the register unchanged.
- R3: When `cpl_valid` is high, each tag whose bit in `cpl_mask` is 1 is cleared on the next edge. Tags whose bit is 0 keep their value.
- R4: If a set and a completion hit the same tag in the same cycle, the tag ends up pending. That tag is not counted as retired.
- R5: `done_tags` gains a bit only for a tag that was pending and was cleared by a completion frame. Completing a tag that was not pending changes neither `done_tags` nor the interrupt.
- R6: When `done_clr_valid` is high, each 1 in `done_clr_mask` clears that bit of `done_tags`. A retirement in the same cycle takes priority over the clear.
- R7: The completion count adds the number of tags each frame actually retires. `irq` rises on the edge at which the count reaches `irq_thresh`, even when a single frame retires several tags.
- R8: When the count stays below the threshold, `irq` rises exactly `irq_timeout` clock edges after the edge that recorded the first unacknowledged completion.
- R9: With `irq_thresh` equal to 1, which is also how a value of 0 is treated, every frame that retires a tag raises `irq` on the same edge that clears the tag.
- R10: `irq_ack` drops `irq` on the next edge and restarts both the count and the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Host set-mask write strobe |
| set_mask | input | NTAGS | Tags to mark pending |
| cpl_valid | input | 1 | Completion frame strobe |
| cpl_mask | input | NTAGS | Tags reported complete (1 = completed) |
| done_clr_valid | input | 1 | Write-1-to-clear strobe for the retired-tag status |
| done_clr_mask | input | NTAGS | Retired-tag bits to clear |
| irq_thresh | input | CNT_W | Completion count that raises the interrupt |
| irq_timeout | input | TMO_W | Cycles from the first completion to a forced interrupt |
| irq_ack | input | 1 | Interrupt acknowledge |
| active_tags | output | NTAGS | Pending-tag register |
| done_tags | output | NTAGS | Retired-tag status |
| irq | output | 1 | Aggregated completion interrupt |

## Verification
The checker checks the per-bit ownership rules on every cycle:
- a set tag is pending after the edge;
- a completed tag that was not set in the same cycle is cleared;
- no tag becomes pending without a set;
- no retired-tag bit appears without a real retirement;
- an acknowledge with nothing new retired drops the interrupt.

Only the bench scenarios can show when the interrupt rises. They sweep the threshold against single-tag and multi-tag frames, and sweep the timeout over several values. They also check that a frame retiring nothing leaves the interrupt quiet.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  parameter int unsigned CQ_NTAGS = 32;
  parameter int unsigned CQ_TMO_W = 16;

  function automatic int unsigned cq_popcnt(input logic [CQ_NTAGS-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < CQ_NTAGS; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/cmdq_tag_reg.sv
module cmdq_tag_reg #(
  parameter int unsigned NTAGS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTAGS-1:0] set_eff,
  input  logic [NTAGS-1:0] clr_eff,
  input  logic [NTAGS-1:0] dclr_eff,
  output logic [NTAGS-1:0] active_q,
  output logic [NTAGS-1:0] done_q,
  output logic [NTAGS-1:0] retired
);
  // A tag retires only if it is pending now and is not being re-issued.
  assign retired = active_q & clr_eff & ~set_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
      done_q   <= '0;
    end else begin
      active_q <= (active_q & ~clr_eff) | set_eff;
      done_q   <= (done_q & ~dclr_eff) | retired;
    end
  end
endmodule

// File: rtl/cmdq_irq_agg.sv
module cmdq_irq_agg
  import cmdq_pkg::*;
#(
  parameter int unsigned NTAGS = 32,
  parameter int unsigned CNT_W = $clog2(NTAGS) + 1,
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTAGS-1:0] retired,
  input  logic [CNT_W-1:0] thresh,
  input  logic [TMO_W-1:0] timeout,
  input  logic             ack,
  output logic             irq_q
);
  localparam logic [CNT_W:0]   CNT_MAX = {1'b0, {CNT_W{1'b1}}};
  localparam logic [TMO_W-1:0] TMR_MAX = {TMO_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, thr_eff, base;
  logic [TMO_W-1:0] tmr_q, tmr_d;
  logic [CNT_W:0]   ncl, sum;
  logic [TMO_W:0]   tmr_inc;
  logic             hit_thr, hit_tmo, irq_d;

  always_comb begin
    ncl     = '0;
    for (int i = 0; i < NTAGS; i++) ncl = ncl + {{CNT_W{1'b0}}, retired[i]};
    base    = ack ? '0 : cnt_q;
    sum     = {1'b0, base} + ncl;
    cnt_d   = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
    thr_eff = (thresh == '0) ? CNT_W'(1) : thresh;
    hit_thr = (cnt_d != '0) && (cnt_d >= thr_eff);
    tmr_inc = {1'b0, tmr_q} + 1'b1;
    hit_tmo = !ack && (cnt_q != '0) && (tmr_inc >= {1'b0, timeout});
    irq_d   = (irq_q && !ack) || hit_thr || hit_tmo;
    if (ack || cnt_q == '0 || irq_q) tmr_d = '0;
    else if (tmr_q == TMR_MAX)        tmr_d = tmr_q;
    else                              tmr_d = tmr_inc[TMO_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tmr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmr_q <= tmr_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/cmdq_tag_tracker.sv
module cmdq_tag_tracker
  import cmdq_pkg::*;
#(
  parameter int unsigned NTAGS = CQ_NTAGS,
  parameter int unsigned CNT_W = $clog2(NTAGS) + 1,
  parameter int unsigned TMO_W = CQ_TMO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_valid,
  input  logic [NTAGS-1:0] set_mask,
  input  logic             cpl_valid,
  input  logic [NTAGS-1:0] cpl_mask,
  input  logic             done_clr_valid,
  input  logic [NTAGS-1:0] done_clr_mask,
  input  logic [CNT_W-1:0] irq_thresh,
  input  logic [TMO_W-1:0] irq_timeout,
  input  logic             irq_ack,
  output logic [NTAGS-1:0] active_tags,
  output logic [NTAGS-1:0] done_tags,
  output logic             irq
);
  logic [NTAGS-1:0] set_eff, clr_eff, dclr_eff, retired;

  assign set_eff  = set_valid      ? set_mask      : '0;
  assign clr_eff  = cpl_valid      ? cpl_mask      : '0;
  assign dclr_eff = done_clr_valid ? done_clr_mask : '0;

  cmdq_tag_reg #(.NTAGS(NTAGS)) u_reg (
    .clk(clk), .rst(rst),
    .set_eff(set_eff), .clr_eff(clr_eff), .dclr_eff(dclr_eff),
    .active_q(active_tags), .done_q(done_tags), .retired(retired)
  );

  cmdq_irq_agg #(.NTAGS(NTAGS), .CNT_W(CNT_W), .TMO_W(TMO_W)) u_agg (
    .clk(clk), .rst(rst), .retired(retired),
    .thresh(irq_thresh), .timeout(irq_timeout), .ack(irq_ack),
    .irq_q(irq)
  );
endmodule

// File: rtl/cmdq_tag_tracker_chk.sv
module cmdq_tag_tracker_chk #(
  parameter int unsigned NTAGS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             set_valid,
  input logic [NTAGS-1:0] set_mask,
  input logic             cpl_valid,
  input logic [NTAGS-1:0] cpl_mask,
  input logic             irq_ack,
  input logic [NTAGS-1:0] active_tags,
  input logic [NTAGS-1:0] done_tags,
  input logic             irq
);
  logic [NTAGS-1:0] hs, cp;
  assign hs = set_valid ? set_mask : '0;
  assign cp = cpl_valid ? cpl_mask : '0;

  p_set_sticks_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((active_tags & $past(hs)) == $past(hs)));

  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((active_tags & ~$past(active_tags)) & ~$past(hs)) == '0));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((active_tags & $past(cp & ~hs)) == '0));

  p_done_real_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((done_tags & ~$past(done_tags)) & ~$past(active_tags & cp & ~hs)) == '0));

  p_ack_drops_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && ((cp & active_tags & ~hs) == '0)) |=> !irq);
endmodule

bind cmdq_tag_tracker cmdq_tag_tracker_chk #(.NTAGS(NTAGS)) u_chk (
  .clk(clk), .rst(rst), .set_valid(set_valid), .set_mask(set_mask),
  .cpl_valid(cpl_valid), .cpl_mask(cpl_mask), .irq_ack(irq_ack),
  .active_tags(active_tags), .done_tags(done_tags), .irq(irq)
);

// File: tb/tb_cmdq_tag_tracker.sv
module tb_cmdq_tag_tracker;
  localparam int N  = 32;
  localparam int CW = 6;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst;
  logic set_valid, cpl_valid, done_clr_valid, irq_ack;
  logic [N-1:0] set_mask, cpl_mask, done_clr_mask;
  logic [CW-1:0] irq_thresh;
  logic [TW-1:0] irq_timeout;
  logic [N-1:0] active_tags, done_tags;
  logic irq;

  int tests = 0, fails = 0;
  logic [N-1:0] m_act, m_done;

  always #2 clk = ~clk;

  cmdq_tag_tracker dut (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_mask(set_mask),
    .cpl_valid(cpl_valid), .cpl_mask(cpl_mask),
    .done_clr_valid(done_clr_valid), .done_clr_mask(done_clr_mask),
    .irq_thresh(irq_thresh), .irq_timeout(irq_timeout), .irq_ack(irq_ack),
    .active_tags(active_tags), .done_tags(done_tags), .irq(irq)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model, check at the following negedge.
  task automatic step(input string req,
                      input logic sv, input logic [N-1:0] sm,
                      input logic cv, input logic [N-1:0] cm,
                      input logic dv, input logic [N-1:0] dm,
                      input logic ack);
    logic [N-1:0] hs, cp, dc, ret;
    set_valid = sv; set_mask = sm; cpl_valid = cv; cpl_mask = cm;
    done_clr_valid = dv; done_clr_mask = dm; irq_ack = ack;
    hs = sv ? sm : '0; cp = cv ? cm : '0; dc = dv ? dm : '0;
    ret    = m_act & cp & ~hs;
    m_act  = (m_act & ~cp) | hs;
    m_done = (m_done & ~dc) | ret;
    @(posedge clk); @(negedge clk);
    set_valid = 0; cpl_valid = 0; done_clr_valid = 0; irq_ack = 0;
    chk({req, " active"}, active_tags, m_act);
    chk({req, " done"}, done_tags, m_done);
  endtask

  task automatic idle(input string req);
    step(req, 0, '0, 0, '0, 0, '0, 0);
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1; set_valid = 0; cpl_valid = 0; done_clr_valid = 0; irq_ack = 0;
    set_mask = '0; cpl_mask = '0; done_clr_mask = '0;
    irq_thresh = CW'(40); irq_timeout = TW'(1000);
    m_act = '0; m_done = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 active", active_tags, '0);
    chk("R1 done", done_tags, '0);
    chk("R1 irq", N'(irq), '0);

    // R2 sweep every tag individually, plus all-zero masks
    for (int t = 0; t < N; t++) step("R2 set", 1, N'(1) << t, 0, '0, 0, '0, 0);
    chk("R2 all set", active_tags, '1);
    step("R2 zero mask", 1, '0, 0, '0, 0, '0, 0);
    step("R2 no strobe", 0, '1, 0, '0, 0, '0, 0);

    // R3/R5 complete odd tags in one frame
    step("R3 odd clear", 0, '0, 1, 32'hAAAA_AAAA, 0, '0, 1);
    chk("R3 evens", active_tags, 32'h5555_5555);
    chk("R5 odds done", done_tags, 32'hAAAA_AAAA);
    // R5 completing non-pending tags retires nothing
    step("R5 stale", 0, '0, 1, 32'hAAAA_AAAA, 0, '0, 1);
    step("R5 stale", 0, '0, 1, 32'h8000_0001, 0, '0, 0);
    chk("R5 only tag0 new", done_tags, 32'hAAAA_AAAB);
    // R4 set and clear of a pending tag in the same cycle
    step("R4 collide", 1, 32'h0000_0004, 1, 32'h0000_0004, 0, '0, 1);
    chk("R4 tag2 pending", active_tags & 32'h4, 32'h4);
    // R6 write-1-clear, with retirement priority
    step("R6 clear", 0, '0, 0, '0, 1, 32'h0000_00FF, 1);
    step("R6 priority", 0, '0, 1, 32'h0000_0010, 1, 32'h0000_0010, 1);
    chk("R6 tag4 kept", done_tags & 32'h10, 32'h10);
    step("R6 clear all", 0, '0, 0, '0, 1, '1, 1);
    chk("R6 empty", done_tags, '0);

    // R7/R9 threshold sweep with single-tag frames
    for (int th = 1; th <= 4; th++) begin
      irq_thresh = CW'(th);
      step("R7 prep", 1, 32'h0000_00FF, 0, '0, 0, '0, 1);
      for (int k = 1; k <= th; k++) begin
        step("R7 cpl", 0, '0, 1, N'(1) << (k - 1), 0, '0, 0);
        chk(th == 1 ? "R9 irq" : "R7 irq", N'(irq), N'(k >= th));
      end
      step("R10 ack", 0, '0, 0, '0, 0, '0, 1);
      chk("R10 irq low", N'(irq), '0);
    end
    // R7 multi-tag frame reaches the threshold at once
    irq_thresh = CW'(3);
    step("R7 prep", 1, 32'h0000_00FF, 0, '0, 0, '0, 1);
    step("R7 multi", 0, '0, 1, 32'h0000_0007, 0, '0, 0);
    chk("R7 multi irq", N'(irq), N'(1));
    step("R10 ack", 0, '0, 0, '0, 0, '0, 1);
    chk("R10 irq low", N'(irq), '0);
    // R9 threshold 0 acts as 1
    irq_thresh = '0;
    step("R9 prep", 1, 32'h0000_0001, 0, '0, 0, '0, 1);
    step("R9 cpl", 0, '0, 1, 32'h0000_0001, 0, '0, 0);
    chk("R9 thr0 irq", N'(irq), N'(1));
    step("R10 ack", 0, '0, 0, '0, 0, '0, 1);

    // R8 timeout sweep, threshold out of reach
    irq_thresh = CW'(31);
    for (int tmo = 1; tmo <= 6; tmo++) begin
      irq_timeout = TW'(tmo);
      step("R8 prep", 1, 32'h0000_0001, 0, '0, 0, '0, 1);
      step("R8 cpl", 0, '0, 1, 32'h0000_0001, 0, '0, 0);
      chk("R8 irq at 0", N'(irq), '0);
      for (int j = 1; j <= tmo; j++) begin
        idle("R8 wait");
        chk("R8 irq", N'(irq), N'(j == tmo));
      end
      step("R10 ack", 0, '0, 0, '0, 0, '0, 1);
      chk("R10 irq low", N'(irq), '0);
    end

    // R5 frame retiring nothing raises no interrupt even after timeout
    irq_thresh = CW'(1); irq_timeout = TW'(2);
    step("R5 empty frame", 0, '0, 1, 32'h0000_0002, 0, '0, 0);
    for (int j = 0; j < 4; j++) idle("R5 wait");
    chk("R5 no irq", N'(irq), '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule